// File: doc/BRIEF.md
# Byte Parity Generator and Checker

This block adds and verifies per-byte parity on a 36-bit word made of four 9-bit bytes. Within each byte, bit 8 is the parity bit and bits 7:0 carry data. On the write stream it can replace every byte's bit 8 with parity computed over that byte's eight data bits. When generation is off, the word passes through untouched. On the read stream it checks all four bytes of each accepted word. A registered stage then presents the word with a single error flag that is high when any byte fails.

The parity sense comes from a plain control input: 0 selects odd parity, which is the default, and 1 selects even parity. Odd parity means each complete 9-bit byte holds an odd number of ones. Even parity means each holds an even number.

Both data paths use valid/ready streams. A word moves when valid and ready are both high at a rising clock edge.

The write path has no storage. Valid flows forward and ready flows backward combinationally, so back-pressure from the write sink reaches the write source in the same cycle.

The read path is a single register stage. It accepts a new word whenever the stage is empty or its current word is being taken in the same cycle. While the downstream holds ready low, the stage keeps its word and its flag frozen.

Top module: `byte_parity_unit`

## Requirements
- R1: With `gen_en`=1, bits 7:0 of every byte on `wr_out_data` equal those of `wr_in_data`, and bit 8 of every byte is replaced by the computed parity bit.
- R2: With `even_sel`=0 (odd), each generated 9-bit byte has an odd count of ones. With `even_sel`=1 (even), each has an even count.
- R3: With `gen_en`=0, `wr_out_data` equals `wr_in_data` in every bit, whatever `even_sel` is.
- R4: `wr_out_valid` follows `wr_in_valid` and `wr_in_ready` follows `wr_out_ready` in the same cycle; the write path stores nothing.
- R5: A read word accepted at a clock edge (`rd_in_valid` and `rd_in_ready` both 1) appears unchanged on `rd_out_data`, with `rd_out_valid`=1, right after that edge.
- R6: `rd_err` is registered and changes on the edge that presents the read word. It is 1 exactly when at least one of the four bytes of that word fails parity under the `even_sel` value sampled at acceptance. `rd_err` is never 1 while `rd_out_valid` is 0.
- R7: While `rd_out_valid`=1 and `rd_out_ready`=0, `rd_in_ready` is 0 and `rd_out_data`, `rd_err` and `rd_out_valid` hold their values.
- R8: After reset, `rd_out_valid`=0 and `rd_err`=0.
- R9: `rd_in_ready` = !`rd_out_valid` || `rd_out_ready`. When the held word is taken and no new word is accepted, `rd_out_valid` and `rd_err` both go to 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | 1: overwrite bit 8 of each byte with generated parity |
| even_sel | input | 1 | Parity sense: 0 odd, 1 even |
| wr_in_valid | input | 1 | Write word valid |
| wr_in_ready | output | 1 | Write word accepted |
| wr_in_data | input | 36 | Write word, byte k at bits 9k+8:9k |
| wr_out_valid | output | 1 | Processed write word valid |
| wr_out_ready | input | 1 | Write sink ready |
| wr_out_data | output | 36 | Write word after optional parity insertion |
| rd_in_valid | input | 1 | Read word valid |
| rd_in_ready | output | 1 | Read stage can accept |
| rd_in_data | input | 36 | Read word to check |
| rd_out_valid | output | 1 | Checked read word valid |
| rd_out_ready | input | 1 | Read sink ready |
| rd_out_data | output | 36 | Checked read word, unchanged |
| rd_err | output | 1 | Parity error in at least one byte of `rd_out_data` |

## Verification
The write path is driven with bytes holding zero, one, two, four, seven and eight ones, under both senses and with generation on and off. These patterns separate an inverted sense, a parity taken over the wrong bits and a leaked pass-through. The read path receives clean words in each sense, words with a single bad byte in different lanes, and a word valid in one sense but checked in the other. Together these show whether the flag ORs all four lanes or only some of them. A stall with a new word offered checks that the stage holds its data and flag, and a drain checks that both clear.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
  localparam int unsigned BP_NUM_BYTES = 4;
  localparam int unsigned BP_DATA_BITS = 8;

  typedef enum logic {
    PAR_ODD  = 1'b0,
    PAR_EVEN = 1'b1
  } par_sense_e;

  // Parity bit to store, given the XOR of the data bits.
  function automatic logic par_fill(input logic xr, input par_sense_e sense);
    return (sense == PAR_EVEN) ? xr : ~xr;
  endfunction

  // A full byte is good when its XOR matches the chosen sense.
  function automatic logic par_good(input logic xr, input par_sense_e sense);
    return (sense == PAR_EVEN) ? ~xr : xr;
  endfunction
endpackage

// File: rtl/bpar_wr_path.sv
module bpar_wr_path
  import bpar_pkg::*;
#(
  parameter int unsigned NUM_BYTES = BP_NUM_BYTES,
  parameter int unsigned DATA_BITS = BP_DATA_BITS,
  localparam int unsigned BYTE_W   = DATA_BITS + 1,
  localparam int unsigned WORD_W   = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_en,
  input  par_sense_e        sense,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic [DATA_BITS-1:0] lane_d;
    logic                 lane_p;
    assign lane_d = in_data[g*BYTE_W +: DATA_BITS];
    assign lane_p = gen_en ? par_fill(^lane_d, sense) : in_data[g*BYTE_W + DATA_BITS];
    assign out_data[g*BYTE_W +: BYTE_W] = {lane_p, lane_d};

    AST_WR_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      out_data[g*BYTE_W +: DATA_BITS] == in_data[g*BYTE_W +: DATA_BITS]); // R1
    AST_WR_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
      gen_en |-> ((^out_data[g*BYTE_W +: BYTE_W]) == (sense == PAR_ODD))); // R2
  end

  AST_WR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> out_data == in_data); // R3
endmodule

// File: rtl/bpar_rd_stage.sv
module bpar_rd_stage
  import bpar_pkg::*;
#(
  parameter int unsigned NUM_BYTES = BP_NUM_BYTES,
  parameter int unsigned DATA_BITS = BP_DATA_BITS,
  localparam int unsigned BYTE_W   = DATA_BITS + 1,
  localparam int unsigned WORD_W   = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  par_sense_e        sense,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              err
);
  logic [NUM_BYTES-1:0] lane_bad;
  logic                 take;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_chk
    assign lane_bad[g] = ~par_good(^in_data[g*BYTE_W +: BYTE_W], sense);
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      err       <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      err       <= |lane_bad;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      err       <= 1'b0;
    end
  end

  AST_RD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid && out_data == $past(in_data)); // R5
  AST_ERR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> out_valid); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(err)); // R7
  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid && !err); // R9
endmodule

// File: rtl/byte_parity_unit.sv
module byte_parity_unit
  import bpar_pkg::*;
#(
  parameter int unsigned NUM_BYTES = BP_NUM_BYTES,
  parameter int unsigned DATA_BITS = BP_DATA_BITS,
  localparam int unsigned WORD_W   = NUM_BYTES * (DATA_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_en,
  input  logic              even_sel,
  input  logic              wr_in_valid,
  output logic              wr_in_ready,
  input  logic [WORD_W-1:0] wr_in_data,
  output logic              wr_out_valid,
  input  logic              wr_out_ready,
  output logic [WORD_W-1:0] wr_out_data,
  input  logic              rd_in_valid,
  output logic              rd_in_ready,
  input  logic [WORD_W-1:0] rd_in_data,
  output logic              rd_out_valid,
  input  logic              rd_out_ready,
  output logic [WORD_W-1:0] rd_out_data,
  output logic              rd_err
);
  par_sense_e sense;
  assign sense = par_sense_e'(even_sel);

  bpar_wr_path #(.NUM_BYTES(NUM_BYTES), .DATA_BITS(DATA_BITS)) u_wr (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .sense(sense),
    .in_valid(wr_in_valid), .in_ready(wr_in_ready), .in_data(wr_in_data),
    .out_valid(wr_out_valid), .out_ready(wr_out_ready), .out_data(wr_out_data)
  );

  bpar_rd_stage #(.NUM_BYTES(NUM_BYTES), .DATA_BITS(DATA_BITS)) u_rd (
    .clk(clk), .rst_n(rst_n), .sense(sense),
    .in_valid(rd_in_valid), .in_ready(rd_in_ready), .in_data(rd_in_data),
    .out_valid(rd_out_valid), .out_ready(rd_out_ready), .out_data(rd_out_data),
    .err(rd_err)
  );

  AST_WR_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_valid == wr_in_valid && wr_in_ready == wr_out_ready); // R4
  AST_RD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_valid && !rd_out_ready |-> !rd_in_ready); // R7
endmodule

// File: tb/byte_parity_unit_bench.sv
module byte_parity_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_en = 1'b0, even_sel = 1'b0;
  logic        wr_in_valid = 1'b0, wr_out_ready = 1'b0;
  logic [35:0] wr_in_data = '0;
  logic        wr_in_ready, wr_out_valid;
  logic [35:0] wr_out_data;
  logic        rd_in_valid = 1'b0, rd_out_ready = 1'b0;
  logic [35:0] rd_in_data = '0;
  logic        rd_in_ready, rd_out_valid, rd_err;
  logic [35:0] rd_out_data;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  byte_parity_unit u_byte_parity_unit (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .even_sel(even_sel),
    .wr_in_valid(wr_in_valid), .wr_in_ready(wr_in_ready), .wr_in_data(wr_in_data),
    .wr_out_valid(wr_out_valid), .wr_out_ready(wr_out_ready), .wr_out_data(wr_out_data),
    .rd_in_valid(rd_in_valid), .rd_in_ready(rd_in_ready), .rd_in_data(rd_in_data),
    .rd_out_valid(rd_out_valid), .rd_out_ready(rd_out_ready), .rd_out_data(rd_out_data),
    .rd_err(rd_err)
  );

  // {gen_en, even_sel, input word, expected output word}
  localparam logic [73:0] WR_VEC [5] = '{
    {1'b1, 1'b0, {9'h000, 9'h001, 9'h003, 9'h0FF}, {9'h100, 9'h001, 9'h103, 9'h1FF}},
    {1'b1, 1'b1, {9'h100, 9'h101, 9'h103, 9'h1FF}, {9'h000, 9'h101, 9'h003, 9'h0FF}},
    {1'b0, 1'b0, {9'h100, 9'h0AA, 9'h1FF, 9'h055}, {9'h100, 9'h0AA, 9'h1FF, 9'h055}},
    {1'b1, 1'b0, {9'h080, 9'h07F, 9'h0AA, 9'h1C3}, {9'h080, 9'h07F, 9'h1AA, 9'h1C3}},
    {1'b0, 1'b1, {9'h1FF, 9'h000, 9'h101, 9'h0C3}, {9'h1FF, 9'h000, 9'h101, 9'h0C3}}
  };
  // {even_sel, word, expected rd_err}
  localparam logic [37:0] RD_VEC [6] = '{
    {1'b0, {9'h100, 9'h001, 9'h103, 9'h1FF}, 1'b0},
    {1'b0, {9'h000, 9'h001, 9'h103, 9'h1FF}, 1'b1},
    {1'b1, {9'h000, 9'h101, 9'h003, 9'h0FF}, 1'b0},
    {1'b1, {9'h000, 9'h101, 9'h003, 9'h1FF}, 1'b1},
    {1'b0, {9'h000, 9'h101, 9'h003, 9'h0FF}, 1'b1},
    {1'b0, {9'h100, 9'h000, 9'h103, 9'h1FF}, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8 valid", 64'(rd_out_valid), 64'd0);
    check("R8 err", 64'(rd_err), 64'd0);
    @(negedge clk) rst_n = 1'b1;

    // write path table (R1 R2 R3)
    foreach (WR_VEC[i]) begin
      @(negedge clk);
      gen_en = WR_VEC[i][73]; even_sel = WR_VEC[i][72];
      wr_in_data = WR_VEC[i][71:36];
      #1;
      check(WR_VEC[i][73] ? "R1/R2 gen" : "R3 pass", 64'(wr_out_data), 64'(WR_VEC[i][35:0]));
    end

    // R4 handshake pass-through
    wr_in_valid = 1'b1; wr_out_ready = 1'b0; #1;
    check("R4 valid", 64'(wr_out_valid), 64'd1);
    check("R4 ready lo", 64'(wr_in_ready), 64'd0);
    wr_in_valid = 1'b0; wr_out_ready = 1'b1; #1;
    check("R4 valid lo", 64'(wr_out_valid), 64'd0);
    check("R4 ready", 64'(wr_in_ready), 64'd1);

    // read path table (R5 R6)
    rd_out_ready = 1'b1;
    foreach (RD_VEC[i]) begin
      @(negedge clk);
      even_sel = RD_VEC[i][37]; rd_in_data = RD_VEC[i][36:1]; rd_in_valid = 1'b1;
      @(posedge clk); #1;
      check("R5 valid", 64'(rd_out_valid), 64'd1);
      check("R5 data", 64'(rd_out_data), 64'(RD_VEC[i][36:1]));
      check("R6 err", 64'(rd_err), 64'(RD_VEC[i][0]));
    end

    // R9 drain: nothing offered, word taken
    @(negedge clk) rd_in_valid = 1'b0;
    @(posedge clk); #1;
    check("R9 valid drop", 64'(rd_out_valid), 64'd0);
    check("R9 err drop", 64'(rd_err), 64'd0);

    // R7 stall: load bad word, block sink, offer a good one, flip sense
    @(negedge clk);
    even_sel = 1'b0; rd_in_data = {9'h000, 9'h001, 9'h103, 9'h1FF}; rd_in_valid = 1'b1;
    rd_out_ready = 1'b0;
    @(posedge clk); #1;
    check("R6 stall load err", 64'(rd_err), 64'd1);
    @(negedge clk);
    rd_in_data = {9'h100, 9'h001, 9'h103, 9'h1FF}; even_sel = 1'b1;
    #1;
    check("R7 in_ready", 64'(rd_in_ready), 64'd0);
    @(posedge clk); #1;
    check("R7 data held", 64'(rd_out_data), 64'({9'h000, 9'h001, 9'h103, 9'h1FF}));
    check("R7 err held", 64'(rd_err), 64'd1);
    check("R7 valid held", 64'(rd_out_valid), 64'd1);

    // R9 ready with full stage: accept while draining
    @(negedge clk) rd_out_ready = 1'b1; even_sel = 1'b0; #1;
    check("R9 in_ready", 64'(rd_in_ready), 64'd1);
    @(posedge clk); #1;
    check("R5 replace data", 64'(rd_out_data), 64'({9'h100, 9'h001, 9'h103, 9'h1FF}));
    check("R6 replace err", 64'(rd_err), 64'd0);

    // R8 reset mid-run with a word held
    @(negedge clk) rd_in_valid = 1'b0; rd_out_ready = 1'b0; rst_n = 1'b0;
    @(posedge clk); #1;
    check("R8 valid after rst", 64'(rd_out_valid), 64'd0);
    check("R8 err after rst", 64'(rd_err), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule